// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

This block gathers the four level-sensitive interrupt pins of every device slot on a bus and folds them onto a small set of shared host interrupt lines. Each slot's pins arrive on one flat input vector. A fixed routing rule picks the host line for each slot and pin pair. The block samples the pins on every clock edge and compares each sample with the level it stored for that pin. Only a change in level moves the counter of the routed line: a rise adds one and a fall subtracts one.

A host line is asserted whenever its counter is non-zero. The line therefore acts as the OR of all the pins routed to it. The pins do not have to be collected in one place, so the same counting scheme can sit at each level of a bridged hierarchy. A synchronous, active-high bus reset clears every counter and every stored pin level. A pin that is still high when reset is released is counted as a fresh rise on the first edge after reset.

Top module: `irq_share_agg`

## Requirements
- R1: While `bus_rst` is sampled high, every counter and every stored pin level becomes zero. A pin that is high when reset is released counts as a rise on the first edge after reset.
- R2: In the default swizzle mode, pin p of slot s sits at bit s*4+p of `pin_lvl` and is routed to host line (p + s) mod NUM_LINES.
- R3: A pin whose sample is 1 while its stored level is 0 raises the counter of its routed line by exactly one, and the stored level becomes 1.
- R4: A pin whose sample is 0 while its stored level is 1 lowers the counter of its routed line by exactly one, and the stored level becomes 0.
- R5: A pin whose sample equals its stored level has no effect on any counter.
- R6: `host_irq[l]` is 1 exactly when the counter of line l is non-zero.
- R7: When several pins change in the same cycle, each counter moves by the net sum of its rises and falls. A rise and a fall on the same line in one cycle leave that counter unchanged.
- R8: The counters are wide enough to count every source. With all pins high and 8 slots on 4 lines, each counter reads 8.
- R9: A pin change sampled at a clock edge shows on `line_cnt` and `host_irq` right after that edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| bus_rst | input | 1 | Synchronous bus reset, active high |
| pin_lvl | input | NUM_SLOTS*4 | Interrupt pin levels; slot s pin p at bit s*4+p |
| host_irq | output | NUM_LINES | Shared level-sensitive host interrupt lines |
| line_cnt | output | NUM_LINES*CNT_W | Per-line count of asserted sources; line l at bits l*CNT_W upward |

## Verification
A stored pin level that drifts away from the pin, or a lost increment or decrement, leaves a counter permanently off by one. That error shows at the ports one edge after the faulty update, either as a count that differs from the number of high pins routed to the line or as a host line that stays high after all of its sources have dropped. A routing fault puts the count on a neighbouring line in the same cycle. Same-cycle rise and fall pairs on one line reveal an update that keeps only one of the two changes. Holding pins high across reset reveals a stored level that survives reset, because the expected rise then never appears.

// File: rtl/irq_share_pkg.sv
package irq_share_pkg;

   localparam int PINS_PER_SLOT = 4;

   typedef enum logic [0:0] {
      ROUTE_SWIZZLE = 1'b0,
      ROUTE_DIRECT  = 1'b1
   } route_mode_e;

   // Host line chosen for one slot/pin pair.
   function automatic int route_line(input int slot, input int pin,
                                     input int lines, input route_mode_e mode);
      int sum;
      if (mode == ROUTE_SWIZZLE) sum = slot + pin;
      else                       sum = pin;
      return sum % lines;
   endfunction

endpackage

// File: rtl/irq_pin_track.sv
module irq_pin_track #(
   parameter int NUM_PINS = 32
) (
   input  logic                clk,
   input  logic                bus_rst,
   input  logic [NUM_PINS-1:0] pin_lvl,
   output logic [NUM_PINS-1:0] seen_q,
   output logic [NUM_PINS-1:0] rise,
   output logic [NUM_PINS-1:0] fall
);

   always_ff @(posedge clk) begin
      if (bus_rst) seen_q <= '0;
      else         seen_q <= pin_lvl;
   end

   always_comb begin
      rise = pin_lvl & ~seen_q;
      fall = ~pin_lvl & seen_q;
   end

endmodule

// File: rtl/irq_line_ctr.sv
module irq_line_ctr
   import irq_share_pkg::*;
#(
   parameter int          NUM_SLOTS = 8,
   parameter int          NUM_LINES = 4,
   parameter int          LINE_IDX  = 0,
   parameter route_mode_e ROUTE     = ROUTE_SWIZZLE,
   parameter int          CNT_W     = 6,
   localparam int         NUM_PINS  = NUM_SLOTS * PINS_PER_SLOT
) (
   input  logic                clk,
   input  logic                bus_rst,
   input  logic [NUM_PINS-1:0] rise,
   input  logic [NUM_PINS-1:0] fall,
   output logic [CNT_W-1:0]    cnt_q
);

   logic [NUM_PINS-1:0] sel;
   logic [CNT_W-1:0]    n_up;
   logic [CNT_W-1:0]    n_dn;

   // Elaboration-time mask of the pins routed to this line.
   for (genvar i = 0; i < NUM_PINS; i++) begin : g_sel
      localparam int SLOT = i / PINS_PER_SLOT;
      localparam int PIN  = i % PINS_PER_SLOT;
      if (route_line(SLOT, PIN, NUM_LINES, ROUTE) == LINE_IDX) begin : g_on
         assign sel[i] = 1'b1;
      end else begin : g_off
         assign sel[i] = 1'b0;
      end
   end

   always_comb begin
      n_up = CNT_W'($countones(rise & sel));
      n_dn = CNT_W'($countones(fall & sel));
   end

   always_ff @(posedge clk) begin
      if (bus_rst) cnt_q <= '0;
      else         cnt_q <= cnt_q + n_up - n_dn;
   end

endmodule

// File: rtl/irq_share_agg.sv
module irq_share_agg
   import irq_share_pkg::*;
#(
   parameter int          NUM_SLOTS = 8,
   parameter int          NUM_LINES = 4,
   parameter route_mode_e ROUTE     = ROUTE_SWIZZLE,
   localparam int         NUM_PINS  = NUM_SLOTS * PINS_PER_SLOT,
   localparam int         CNT_W     = $clog2(NUM_PINS + 1)
) (
   input  logic                       clk,
   input  logic                       bus_rst,
   input  logic [NUM_PINS-1:0]        pin_lvl,
   output logic [NUM_LINES-1:0]       host_irq,
   output logic [NUM_LINES*CNT_W-1:0] line_cnt
);

   if (NUM_SLOTS < 1) begin : g_bad_slots
      $error("irq_share_agg: NUM_SLOTS must be at least 1");
   end
   if (NUM_LINES < 1) begin : g_bad_lines
      $error("irq_share_agg: NUM_LINES must be at least 1");
   end

   logic [NUM_PINS-1:0] seen_q;
   logic [NUM_PINS-1:0] rise;
   logic [NUM_PINS-1:0] fall;

   irq_pin_track #(.NUM_PINS(NUM_PINS)) u_track (
      .clk     (clk),
      .bus_rst (bus_rst),
      .pin_lvl (pin_lvl),
      .seen_q  (seen_q),
      .rise    (rise),
      .fall    (fall)
   );

   for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      logic [CNT_W-1:0] cnt;

      irq_line_ctr #(
         .NUM_SLOTS (NUM_SLOTS),
         .NUM_LINES (NUM_LINES),
         .LINE_IDX  (l),
         .ROUTE     (ROUTE),
         .CNT_W     (CNT_W)
      ) u_ctr (
         .clk     (clk),
         .bus_rst (bus_rst),
         .rise    (rise),
         .fall    (fall),
         .cnt_q   (cnt)
      );

      assign line_cnt[l*CNT_W +: CNT_W] = cnt;
      assign host_irq[l]                = (cnt != '0);
   end

endmodule

// File: rtl/irq_share_agg_chk.sv
module irq_share_agg_chk #(
   parameter int NUM_PINS  = 32,
   parameter int NUM_LINES = 4,
   parameter int CNT_W     = 6
) (
   input logic                       clk,
   input logic                       bus_rst,
   input logic [NUM_PINS-1:0]        pin_lvl,
   input logic [NUM_PINS-1:0]        seen_q,
   input logic [NUM_LINES-1:0]       host_irq,
   input logic [NUM_LINES*CNT_W-1:0] line_cnt
);

   int total;

   always_comb begin
      total = 0;
      for (int l = 0; l < NUM_LINES; l++)
         total += int'(line_cnt[l*CNT_W +: CNT_W]);
   end

   AST_RST_CLEAR: assert property (@(posedge clk)
      $past(bus_rst) |-> (line_cnt == '0 && seen_q == '0)); // R1

   AST_SEEN_FOLLOW: assert property (@(posedge clk) disable iff (bus_rst)
      !$past(bus_rst) |-> seen_q == $past(pin_lvl)); // R3

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (bus_rst)
      (seen_q == pin_lvl) |=> $stable(line_cnt)); // R5

   AST_OUT_SOURCE: assert property (@(posedge clk) disable iff (bus_rst)
      (host_irq != '0) |-> (seen_q != '0)); // R6

   AST_SUM_MATCH: assert property (@(posedge clk) disable iff (bus_rst)
      total == $countones(seen_q)); // R7

   for (genvar l = 0; l < NUM_LINES; l++) begin : g_ovf
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (bus_rst)
         int'(line_cnt[l*CNT_W +: CNT_W]) <= NUM_PINS); // R8
   end

endmodule

bind irq_share_agg irq_share_agg_chk #(
   .NUM_PINS  (NUM_PINS),
   .NUM_LINES (NUM_LINES),
   .CNT_W     (CNT_W)
) u_chk (
   .clk      (clk),
   .bus_rst  (bus_rst),
   .pin_lvl  (pin_lvl),
   .seen_q   (seen_q),
   .host_irq (host_irq),
   .line_cnt (line_cnt)
);

// File: tb/tb_irq_share_agg.sv
module tb_irq_share_agg;

   localparam int CLK_PERIOD = 10;
   localparam int NSLOT      = 8;
   localparam int NLINE      = 4;
   localparam int NPIN       = NSLOT * 4;
   localparam int CW         = 6;

   typedef struct packed {
      logic [31:0] lvl;
      logic [31:0] exp;   // expected counts, one byte per line, line 0 lowest
   } vec_t;

   localparam vec_t VECS [10] = '{
      '{32'h0000_0000, 32'h0000_0000},   // R1 start from zero
      '{32'h0000_0001, 32'h0000_0001},   // R2 R3 slot0 pin0 -> line0
      '{32'h0000_0011, 32'h0000_0101},   // R2 slot1 pin0 -> line1
      '{32'h0000_2011, 32'h0000_0102},   // R2 slot3 pin1 -> line0
      '{32'h0000_2410, 32'h0000_0102},   // R7 fall+rise on line0 same cycle
      '{32'hFFFF_FFFF, 32'h0808_0808},   // R8 every source high
      '{32'hFFFF_FFFF, 32'h0808_0808},   // R5 steady levels
      '{32'h0000_000F, 32'h0101_0101},   // R4 mass fall
      '{32'h8000_0000, 32'h0001_0000},   // R2 slot7 pin3 -> line2
      '{32'h0000_0000, 32'h0000_0000}    // R4 back to idle
   };

   logic               clk = 1'b0;
   logic               bus_rst = 1'b1;
   logic [NPIN-1:0]    pin_lvl = '0;
   logic [NLINE-1:0]   host_irq;
   logic [NLINE*CW-1:0] line_cnt;

   int checks = 0;
   int errors = 0;

   irq_share_agg #(.NUM_SLOTS(NSLOT), .NUM_LINES(NLINE)) dut (
      .clk      (clk),
      .bus_rst  (bus_rst),
      .pin_lvl  (pin_lvl),
      .host_irq (host_irq),
      .line_cnt (line_cnt)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   // Compare all line counters and host lines with a packed byte-per-line value.
   task automatic check_lines(input string req, input logic [31:0] exp);
      logic [NLINE-1:0] exp_irq;
      for (int l = 0; l < NLINE; l++) begin
         check(req, int'(line_cnt[l*CW +: CW]), int'(exp[l*8 +: 8]));
         exp_irq[l] = (exp[l*8 +: 8] != 8'd0);
      end
      check({req, " R6"}, int'(host_irq), int'(exp_irq));
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check_lines("R1 reset state", 32'h0);
      bus_rst = 1'b0;

      for (int v = 0; v < 10; v++) begin
         @(negedge clk);
         pin_lvl = VECS[v].lvl;
         @(negedge clk);
         check_lines($sformatf("R2 R3 R4 R7 vector %0d", v), VECS[v].exp);
      end

      // R1: pins held high through reset are seen as rises after release
      @(negedge clk);
      pin_lvl = 32'h0000_000F;
      @(negedge clk);
      check_lines("R3 pre-reset", 32'h0101_0101);
      bus_rst = 1'b1;
      @(negedge clk);
      check_lines("R1 cleared in reset", 32'h0);
      bus_rst = 1'b0;
      @(negedge clk);
      check_lines("R1 rise after release", 32'h0101_0101);

      // R9: no change before the edge, change right after it
      pin_lvl = 32'h0;
      #1;
      check_lines("R9 before edge", 32'h0101_0101);
      @(negedge clk);
      check_lines("R9 after edge", 32'h0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule